// File: doc/BRIEF.md
# Ready-Latency Two-to-One Stream Adapter

This block connects a streaming source that honours a ready latency of two cycles to a sink that expects a ready latency of one cycle. Such a source is typical after a function whose output register adds a cycle between the ready it sees and the data it produces. Each beat carries a data word and three framing flags: start of packet, end of packet and a sync marker. The flags stay attached to their word from input to output.

The sink's ready input goes straight into the enable of the output register. The ready sent back to the source comes from a flip-flop and does not follow the sink's ready combinationally. After the upstream ready falls, the source may still deliver two beats. These land in a small circular store, three words deep by default. When the store is empty and the sink is ready, an incoming beat skips the store and goes straight to the output register. This keeps the pipeline delay at one cycle and allows full throughput.

Top module: `stream_rl2_to_rl1`

## Requirements
- R1: While `rst` is high, `out_valid`, `out_sop`, `out_eop`, `out_sync` and `in_ready` are all low. In the first cycle after `rst` is released, `in_ready` is high.
- R2: `out_valid` is high in a cycle only if `out_ready` was high in the previous cycle.
- R3: Under any pattern of `out_ready`, every input beat appears at the output exactly once and in arrival order, with its data unchanged.
- R4: While `out_ready` is held high, a beat presented in cycle t appears at the output in cycle t+1.
- R5: Each beat keeps its own `sop`, `eop` and `sync` values. When `out_valid` is low, all three output flags are low.
- R6: `in_ready` is driven from a register and never admits more beats than the store can hold. From steady full-rate streaming, stalling the sink lets exactly DEPTH further beats enter before the source is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream beat valid |
| in_data | input | DATA_W | Upstream data word |
| in_sop | input | 1 | Upstream start-of-packet flag |
| in_eop | input | 1 | Upstream end-of-packet flag |
| in_sync | input | 1 | Upstream sync marker |
| in_ready | output | 1 | Registered ready to the source, latency two |
| out_ready | input | 1 | Ready from the sink, latency one |
| out_valid | output | 1 | Downstream beat valid |
| out_data | output | DATA_W | Downstream data word |
| out_sop | output | 1 | Downstream start-of-packet flag |
| out_eop | output | 1 | Downstream end-of-packet flag |
| out_sync | output | 1 | Downstream sync marker |

## Verification
The assertions assume that the source obeys its contract: `in_valid` rises only in a cycle whose `in_ready` two cycles earlier was high. They also assume that no beat arrives during reset. If either assumption breaks, the store could overflow and the overflow check would fire even though the adapter is correct. The bench's source model keeps a two-deep history of `in_ready` and sends only when the older entry is high. In random mode it sends on a coin flip within that allowance, and it stays silent while reset is asserted.

// File: rtl/rla_pkg.sv
package rla_pkg;

    // Framing flags that travel beside each data word.
    typedef struct packed {
        logic sync;
        logic sop;
        logic eop;
    } beat_flags_t;

    localparam int unsigned FLAG_W = 3;

    // True when the store, with the beats already promised to the source,
    // still has room for one more promised beat.
    function automatic logic may_open(input int unsigned fill,
                                      input int unsigned pending,
                                      input int unsigned depth);
        return (fill + pending + 1) <= depth;
    endfunction

endpackage

// File: rtl/rl_beat_store.sv
module rl_beat_store #(
    parameter int unsigned BEAT_W = 11,
    parameter int unsigned DEPTH  = 3,
    localparam int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic [BEAT_W-1:0] push_beat,
    input  logic              pop,
    output logic [BEAT_W-1:0] head,
    output logic [CW-1:0]     fill
);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [BEAT_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr, rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_beat;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            fill <= fill + CW'(push) - CW'(pop);
        end
    end

    assign head = mem[rd_ptr];

endmodule

// File: rtl/rl_ready_gen.sv
module rl_ready_gen #(
    parameter int unsigned DEPTH = 3,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] fill_next,
    output logic          in_ready
);
    // in_ready of this cycle and of the previous cycle: each one may still
    // bring a beat in the next two cycles.
    logic rdy_now, rdy_prev;
    logic open_next;

    always_comb begin
        open_next = rla_pkg::may_open(int'(fill_next),
                                      int'(rdy_now) + int'(rdy_prev),
                                      DEPTH);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_now  <= 1'b0;
            rdy_prev <= 1'b0;
        end else begin
            rdy_now  <= open_next;
            rdy_prev <= rdy_now;
        end
    end

    assign in_ready = rdy_now;

endmodule

// File: rtl/stream_rl2_to_rl1.sv
module stream_rl2_to_rl1 #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 3,
    localparam int unsigned BEAT_W = DATA_W + rla_pkg::FLAG_W,
    localparam int unsigned CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic              in_sync,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sop,
    output logic              out_eop,
    output logic              out_sync
);
    import rla_pkg::*;

    logic [BEAT_W-1:0] in_beat, head_beat, next_beat;
    logic [CW-1:0]     fill_w, fill_next;
    logic              push_w, pop_w, load_w;
    beat_flags_t       in_flags, next_flags, out_flags;
    logic [DATA_W-1:0] next_data, out_data_q;
    logic              out_valid_q;

    assign in_flags = '{sync: in_sync, sop: in_sop, eop: in_eop};
    assign in_beat  = {in_flags, in_data};

    // Steering: the sink takes a new beat only when its ready is high; the
    // store feeds first, an arriving beat bypasses an empty store.
    always_comb begin
        pop_w     = 1'b0;
        push_w    = in_valid;
        load_w    = 1'b0;
        next_beat = in_beat;
        if (out_ready) begin
            if (fill_w != '0) begin
                pop_w     = 1'b1;
                load_w    = 1'b1;
                next_beat = head_beat;
            end else if (in_valid) begin
                push_w = 1'b0;
                load_w = 1'b1;
            end
        end
        fill_next = fill_w + CW'(push_w) - CW'(pop_w);
    end

    assign {next_flags, next_data} = next_beat;

    rl_beat_store #(
        .BEAT_W (BEAT_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (push_w),
        .push_beat (in_beat),
        .pop       (pop_w),
        .head      (head_beat),
        .fill      (fill_w)
    );

    rl_ready_gen #(
        .DEPTH (DEPTH)
    ) u_ready (
        .clk       (clk),
        .rst       (rst),
        .fill_next (fill_next),
        .in_ready  (in_ready)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid_q <= 1'b0;
            out_flags   <= '0;
            out_data_q  <= '0;
        end else begin
            out_valid_q <= load_w;
            if (load_w) begin
                out_flags  <= next_flags;
                out_data_q <= next_data;
            end else begin
                out_flags  <= '0;
            end
        end
    end

    assign out_valid = out_valid_q;
    assign out_data  = out_data_q;
    assign out_sop   = out_flags.sop;
    assign out_eop   = out_flags.eop;
    assign out_sync  = out_flags.sync;

endmodule

// File: rtl/stream_rl2_to_rl1_chk.sv
module stream_rl2_to_rl1_chk #(
    parameter int unsigned DEPTH = 3,
    parameter int unsigned CW    = 2
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          in_ready,
    input logic          out_ready,
    input logic          out_valid,
    input logic          out_sop,
    input logic          out_eop,
    input logic          out_sync,
    input logic          push,
    input logic          pop,
    input logic [CW-1:0] fill
);
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !in_ready)); // R1

    AST_OUT_AFTER_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(out_ready)); // R2

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        pop |-> (fill != '0)); // R3

    AST_FLAGS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !(out_sop || out_eop || out_sync)); // R5

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (push && !pop) |-> (int'(fill) < DEPTH)); // R6

    AST_SRC_OBEYS: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> $past(in_ready, 2)); // R6

endmodule

bind stream_rl2_to_rl1 stream_rl2_to_rl1_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_sop   (out_sop),
    .out_eop   (out_eop),
    .out_sync  (out_sync),
    .push      (push_w),
    .pop       (pop_w),
    .fill      (fill_w)
);

// File: tb/sim_stream_rl2_to_rl1.sv
`timescale 1ns/1ps
module sim_stream_rl2_to_rl1;
    localparam int unsigned DATA_W = 8;
    localparam int unsigned DEPTH  = 3;
    localparam int unsigned BW     = DATA_W + 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0, in_sync = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic in_ready;
    logic out_ready = 1'b0;
    logic out_valid, out_sop, out_eop, out_sync;
    logic [DATA_W-1:0] out_data;

    always #10 clk = ~clk;

    stream_rl2_to_rl1 #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_data(in_data), .in_sop(in_sop),
        .in_eop(in_eop), .in_sync(in_sync), .in_ready(in_ready),
        .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
        .out_sop(out_sop), .out_eop(out_eop), .out_sync(out_sync)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int src_mode = 0;   // 0 silent, 1 full allowance, 2 random within allowance
    int snk_mode = 0;   // 0 ready low, 1 ready high, 2 random
    bit lat_check = 1'b0;
    int sent_cnt = 0;
    int idx = 0;
    bit h1 = 1'b0, h2 = 1'b0;
    bit done = 1'b0;
    logic [BW-1:0] q_beat[$];
    int q_cyc[$];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [BW-1:0] make_beat(input int n);
        logic s, p, e;
        s = (n % 16) == 0;
        p = (n % 4) == 0;
        e = (n % 4) == 3;
        return {s, p, e, DATA_W'(n * 7 + 3)};
    endfunction

    // Source, sink and monitor models, all acting at the falling edge.
    always @(negedge clk) begin
        logic allow, send;
        logic [BW-1:0] b;
        cyc++;
        if (!rst) begin
            chk(out_valid || !(out_sop || out_eop || out_sync), "R5 flags while idle",
                {out_sync, out_sop, out_eop}, 0);
            if (out_valid) begin
                chk(out_ready, "R2 valid after ready", out_ready, 1);
                if (q_beat.size() == 0) begin
                    chk(1'b0, "R3 unexpected beat", out_data, -1);
                end else begin
                    chk({out_sync, out_sop, out_eop, out_data} == q_beat[0], "R3 R5 beat content",
                        {out_sync, out_sop, out_eop, out_data}, q_beat[0]);
                    if (lat_check) begin
                        chk(cyc - q_cyc[0] == 1, "R4 fixed delay", cyc - q_cyc[0], 1);
                    end
                    void'(q_beat.pop_front());
                    void'(q_cyc.pop_front());
                end
            end
        end
        allow = h2;
        h2 = h1;
        h1 = in_ready;
        send = !rst && allow && (src_mode == 1 || (src_mode == 2 && $urandom_range(1, 0) == 1));
        b = make_beat(idx);
        in_valid <= send;
        {in_sync, in_sop, in_eop, in_data} <= send ? b : '0;
        if (send) begin
            q_beat.push_back(b);
            q_cyc.push_back(cyc);
            idx++;
            sent_cnt++;
        end
        case (snk_mode)
            0: out_ready <= 1'b0;
            1: out_ready <= 1'b1;
            default: out_ready <= ($urandom_range(3, 0) != 0);
        endcase
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic drain_and_check(input string tag);
        src_mode = 0;
        snk_mode = 1;
        tick(20);
        chk(q_beat.size() == 0, tag, q_beat.size(), 0);
    endtask

    task automatic test_reset();
        tick(3);
        chk(!out_valid, "R1 out_valid in reset", out_valid, 0);
        chk(!(out_sop || out_eop || out_sync), "R1 flags in reset", {out_sync, out_sop, out_eop}, 0);
        chk(!in_ready, "R1 in_ready in reset", in_ready, 0);
        rst = 1'b0;
        tick(1);
        chk(in_ready, "R1 in_ready after release", in_ready, 1);
        chk(!out_valid, "R1 out_valid after release", out_valid, 0);
    endtask

    task automatic test_passthrough();
        snk_mode = 1;
        tick(3);
        lat_check = 1'b1;
        src_mode = 1;
        tick(60);
        src_mode = 0;
        tick(4);
        lat_check = 1'b0;
        chk(in_ready, "R4 ready stays high when streaming", in_ready, 1);
        drain_and_check("R4 all beats out");
    endtask

    task automatic test_stall();
        int base;
        snk_mode = 1;
        src_mode = 1;
        tick(20);
        base = sent_cnt;
        snk_mode = 0;
        tick(10);
        chk(sent_cnt - base == DEPTH, "R6 beats accepted during stall", sent_cnt - base, DEPTH);
        chk(!in_ready, "R6 in_ready low when full", in_ready, 0);
        chk(!out_valid, "R2 no output while stalled", out_valid, 0);
        drain_and_check("R6 stalled beats drained");
    endtask

    task automatic test_random();
        src_mode = 2;
        snk_mode = 2;
        tick(3000);
        drain_and_check("R3 random traffic complete");
        src_mode = 1;
        snk_mode = 2;
        tick(2000);
        drain_and_check("R3 full source, random sink");
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        test_reset();
        test_passthrough();
        test_stall();
        test_random();
        test_stall();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R3 watchdog: actual %0d expected %0d", 0, 1);
            finish_run();
        end
    end

endmodule